// File: doc/BRIEF.md
# Codec Power-Up Sequencer

This block sits on the host side of an audio codec that is controlled by software. It brings the codec out of reset in a fixed order. It holds the codec's reset line low until the board supply has been good for a minimum time. It then issues register writes through a simple request/acknowledge command port that feeds an external serial-bus master.

The first write sets the power-down bit, which keeps the codec parked while a parameter table of address/data pairs is loaded. The master clock is then switched on. A second write to the power register clears the power-down bit. Last, the frame clock, the bit clock and the serial data path are enabled. The block counts a programmed number of frame-clock periods before it raises `ready`.

A write that comes back not acknowledged is repeated a bounded number of times. When the retries run out, the sequencer parks in a fault state, raises a sticky error flag and holds the codec in reset. If the supply-good input falls at any point, everything restarts from the reset-hold state.

Top module: `codec_pwrup_seq`

## Requirements
- R1: `codec_rst_n` stays low while `supply_ok` is low. After `supply_ok` has been high for RST_MIN_CYCLES consecutive clock edges, `codec_rst_n` rises on the following edge. Any low cycle of `supply_ok` during the hold restarts the count.
- R2: The first command after reset release is a write of data 0x01 to address 0x02 (bit 0 of the power register is the power-down bit). `cmd_valid` rises STEP_CYCLES+1 edges after `codec_rst_n` rose.
- R3: The configuration entries follow in table order. Entry i sits at CFG_TABLE bits [16i+15:16i], with the register address in the upper byte and the data in the lower byte. All of them are written with `mclk_en` low, and no entry may address the power register.
- R4: A command keeps `cmd_valid` high with `cmd_addr`/`cmd_data` stable until a `cmd_done` pulse. `cmd_nack` high together with `cmd_done` means the write was not acknowledged. A new command is not issued before the previous one is done.
- R5: `mclk_en` rises only after the last configuration write has been acknowledged, and before power-down is cleared.
- R6: Once `mclk_en` is high, a write of data 0x00 to address 0x02 clears power-down.
- R7: `aif_en` (frame clock, bit clock and serial data) rises only after the power-down clear is acknowledged, and it is never high without `mclk_en`.
- R8: Only rising edges of `frame_clk` seen while `aif_en` is high are counted. `ready` rises on the fourth clock edge after the SETTLE_FRAMES-th such edge, and not before.
- R9: A clock edge with `supply_ok` low forces `codec_rst_n`, `cmd_valid`, `mclk_en`, `aif_en` and `ready` low from the next cycle on. A `cmd_done` pulse in that same cycle is ignored, and the sequence restarts from R1.
- R10: A not-acknowledged write is reissued with the same address and data, up to MAX_RETRIES times.
- R11: A write not acknowledged MAX_RETRIES+1 times in a row sends the block to a fault state. In that state `err_flag` is high, the codec is held in reset, the clocks are off and no command is issued. `err_flag` stays high, even across a supply restart and a complete bring-up, until `rst_n` goes low.
- R12: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| supply_ok | input | 1 | Board supply-good indication |
| codec_rst_n | output | 1 | Active-low reset line to the codec |
| cmd_valid | output | 1 | Register write request to the serial-bus master |
| cmd_addr | output | 8 | Register address of the pending write |
| cmd_data | output | 8 | Data byte of the pending write |
| cmd_done | input | 1 | One-cycle completion pulse from the serial-bus master |
| cmd_nack | input | 1 | Qualifies `cmd_done`: the write was not acknowledged |
| mclk_en | output | 1 | Enables the codec master clock |
| aif_en | output | 1 | Enables frame clock, bit clock and serial data |
| frame_clk | input | 1 | Frame clock, used to count sample periods |
| ready | output | 1 | Codec is initialised and ready for audio |
| err_flag | output | 1 | Sticky flag: a write exhausted its retries |

## Verification
The hard coincidence is a supply drop that arrives in the same clock cycle as the completion pulse of a configuration write. The supply path has to win: the acknowledge must not advance the table index, and the restart must begin again at the power-down write. The bench drops `supply_ok` on the same falling edge on which its bus-master model drives an acknowledged `cmd_done`. It then checks that every output is low one cycle later. The scoreboard then expects the whole command list again, starting with the power-down set. A second overlap, a not-acknowledge on the retry that exhausts the budget, is judged by the number of attempts seen and by the fault outputs.

// File: rtl/codec_pwrup_pkg.sv
package codec_pwrup_pkg;

   localparam int REG_AW = 8;
   localparam int REG_DW = 8;

   typedef struct packed {
      logic [REG_AW-1:0] addr;
      logic [REG_DW-1:0] data;
   } reg_wr_t;

   localparam int REG_WR_W = $bits(reg_wr_t);

   typedef enum logic [2:0] {
      SEQ_RST_HOLD   = 3'd0,
      SEQ_PDN_SET    = 3'd1,
      SEQ_CFG_LOAD   = 3'd2,
      SEQ_MCLK_ON    = 3'd3,
      SEQ_PDN_CLR    = 3'd4,
      SEQ_AIF_SETTLE = 3'd5,
      SEQ_READY      = 3'd6,
      SEQ_FAULT      = 3'd7
   } seq_state_e;

endpackage

// File: rtl/pwrup_delay_timer.sv
module pwrup_delay_timer #(
   parameter int unsigned MAX_CYCLES = 1000,
   parameter int unsigned RESET_VAL  = MAX_CYCLES,
   parameter int unsigned CNT_W      = $clog2(MAX_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   initial begin : chk_params
      if (RESET_VAL > MAX_CYCLES) $fatal(1, "timer reset value exceeds its range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_W'(RESET_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrup_frame_counter.sv
module pwrup_frame_counter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FRAMES      = 2000,
   parameter int unsigned CNT_W       = $clog2(FRAMES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic frame_clk,
   output logic reached
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;
   logic [CNT_W-1:0]       cnt_q;

   initial begin : chk_params
      if (SYNC_STAGES < 2) $fatal(1, "frame clock needs at least two sync stages");
      if (FRAMES < 1)      $fatal(1, "settle frame count must be at least one");
   end

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= frame_clk;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enable) begin
         cnt_q <= '0;
      end else if (rise && (cnt_q != CNT_W'(FRAMES))) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign reached = (cnt_q == CNT_W'(FRAMES));

endmodule

// File: rtl/pwrup_cfg_rom.sv
module pwrup_cfg_rom
   import codec_pwrup_pkg::*;
#(
   parameter int unsigned                     COUNT = 4,
   parameter logic [COUNT*REG_WR_W-1:0]       TABLE = '0,
   parameter int unsigned                     IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
   input  logic [IDX_W-1:0] idx,
   output reg_wr_t          entry
);

   reg_wr_t rom [COUNT];

   generate
      for (genvar i = 0; i < COUNT; i++) begin : g_entry
         assign rom[i] = TABLE[i*REG_WR_W +: REG_WR_W];
      end
   endgenerate

   always_comb begin
      entry = rom[0];
      for (int i = 0; i < COUNT; i++) begin
         if (idx == IDX_W'(i)) entry = rom[i];
      end
   end

endmodule

// File: rtl/codec_pwrup_seq.sv
module codec_pwrup_seq
   import codec_pwrup_pkg::*;
#(
   parameter int unsigned                   RST_MIN_CYCLES = 1000,
   parameter int unsigned                   STEP_CYCLES    = 100,
   parameter int unsigned                   SETTLE_FRAMES  = 2000,
   parameter int unsigned                   MAX_RETRIES    = 3,
   parameter int unsigned                   SYNC_STAGES    = 2,
   parameter logic [REG_AW-1:0]             PWR_REG_ADDR   = 8'h02,
   parameter int unsigned                   PDN_BIT        = 0,
   parameter int unsigned                   CFG_COUNT      = 4,
   parameter logic [CFG_COUNT*REG_WR_W-1:0] CFG_TABLE      =
      {16'h0A_00, 16'h09_00, 16'h06_10, 16'h03_A1}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_ok,
   output logic              codec_rst_n,
   output logic              cmd_valid,
   output logic [REG_AW-1:0] cmd_addr,
   output logic [REG_DW-1:0] cmd_data,
   input  logic              cmd_done,
   input  logic              cmd_nack,
   output logic              mclk_en,
   output logic              aif_en,
   input  logic              frame_clk,
   output logic              ready,
   output logic              err_flag
);

   localparam int unsigned TMR_MAX = (RST_MIN_CYCLES > STEP_CYCLES) ? RST_MIN_CYCLES : STEP_CYCLES;
   localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
   localparam int unsigned CFG_IW  = (CFG_COUNT > 1) ? $clog2(CFG_COUNT) : 1;
   localparam int unsigned RTY_W   = $clog2(MAX_RETRIES + 1);
   localparam logic [CFG_IW-1:0] CFG_LAST  = CFG_IW'(CFG_COUNT - 1);
   localparam logic [REG_DW-1:0] PDN_MASK  = REG_DW'(1) << PDN_BIT;

   initial begin : chk_params
      if (RST_MIN_CYCLES < 1) $fatal(1, "reset hold must be at least one cycle");
      if (STEP_CYCLES < 1)    $fatal(1, "step delay must be at least one cycle");
      if (MAX_RETRIES < 1)    $fatal(1, "retry budget must be at least one");
      if (CFG_COUNT < 1)      $fatal(1, "configuration table must not be empty");
      if (PDN_BIT >= REG_DW)  $fatal(1, "power-down bit outside the data byte");
      for (int i = 0; i < CFG_COUNT; i++) begin
         if (CFG_TABLE[i*REG_WR_W+REG_DW +: REG_AW] == PWR_REG_ADDR)
            $fatal(1, "configuration table must not address the power register");
      end
   end

   seq_state_e        state_q;
   logic              wr_busy_q;
   logic [CFG_IW-1:0] cfg_idx_q;
   logic [RTY_W-1:0]  retry_q;
   logic              err_q;

   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_exp;
   logic              frames_done;
   logic              wr_state;
   logic              wr_ack;
   logic              wr_nak;
   reg_wr_t           rom_entry;
   reg_wr_t           cur_wr;

   pwrup_delay_timer #(
      .MAX_CYCLES (TMR_MAX),
      .RESET_VAL  (RST_MIN_CYCLES),
      .CNT_W      (TMR_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   pwrup_frame_counter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FRAMES      (SETTLE_FRAMES)
   ) u_frames (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (state_q == SEQ_AIF_SETTLE),
      .frame_clk (frame_clk),
      .reached   (frames_done)
   );

   pwrup_cfg_rom #(
      .COUNT (CFG_COUNT),
      .TABLE (CFG_TABLE),
      .IDX_W (CFG_IW)
   ) u_rom (
      .idx   (cfg_idx_q),
      .entry (rom_entry)
   );

   assign wr_state = (state_q == SEQ_PDN_SET) || (state_q == SEQ_CFG_LOAD) ||
                     (state_q == SEQ_PDN_CLR);
   assign wr_ack   = wr_busy_q & cmd_done & ~cmd_nack;
   assign wr_nak   = wr_busy_q & cmd_done &  cmd_nack;

   always_comb begin
      tmr_load = !supply_ok || wr_ack || wr_nak ||
                 (tmr_exp && ((state_q == SEQ_RST_HOLD) || (state_q == SEQ_MCLK_ON)));
      tmr_val  = supply_ok ? TMR_W'(STEP_CYCLES) : TMR_W'(RST_MIN_CYCLES);
   end

   always_comb begin
      case (state_q)
         SEQ_PDN_SET: cur_wr = '{addr: PWR_REG_ADDR, data: PDN_MASK};
         SEQ_PDN_CLR: cur_wr = '{addr: PWR_REG_ADDR, data: '0};
         default:     cur_wr = rom_entry;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_RST_HOLD;
         wr_busy_q <= 1'b0;
         cfg_idx_q <= '0;
         retry_q   <= '0;
         err_q     <= 1'b0;
      end else if (!supply_ok) begin
         state_q   <= SEQ_RST_HOLD;
         wr_busy_q <= 1'b0;
         cfg_idx_q <= '0;
         retry_q   <= '0;
      end else begin
         case (state_q)
            SEQ_RST_HOLD: begin
               if (tmr_exp) state_q <= SEQ_PDN_SET;
            end
            SEQ_PDN_SET, SEQ_CFG_LOAD, SEQ_PDN_CLR: begin
               if (!wr_busy_q && tmr_exp) begin
                  wr_busy_q <= 1'b1;
               end else if (wr_ack) begin
                  wr_busy_q <= 1'b0;
                  retry_q   <= '0;
                  case (state_q)
                     SEQ_PDN_SET:  state_q <= SEQ_CFG_LOAD;
                     SEQ_CFG_LOAD: begin
                        if (cfg_idx_q == CFG_LAST) state_q   <= SEQ_MCLK_ON;
                        else                       cfg_idx_q <= cfg_idx_q + 1'b1;
                     end
                     default:      state_q <= SEQ_AIF_SETTLE;
                  endcase
               end else if (wr_nak) begin
                  wr_busy_q <= 1'b0;
                  if (retry_q == RTY_W'(MAX_RETRIES)) begin
                     state_q <= SEQ_FAULT;
                     err_q   <= 1'b1;
                  end else begin
                     retry_q <= retry_q + 1'b1;
                  end
               end
            end
            SEQ_MCLK_ON: begin
               if (tmr_exp) state_q <= SEQ_PDN_CLR;
            end
            SEQ_AIF_SETTLE: begin
               if (frames_done) state_q <= SEQ_READY;
            end
            default: ;
         endcase
      end
   end

   assign codec_rst_n = (state_q != SEQ_RST_HOLD) && (state_q != SEQ_FAULT);
   assign cmd_valid   = wr_busy_q & wr_state;
   assign cmd_addr    = cur_wr.addr;
   assign cmd_data    = cur_wr.data;
   assign mclk_en     = (state_q == SEQ_MCLK_ON) || (state_q == SEQ_PDN_CLR) ||
                        (state_q == SEQ_AIF_SETTLE) || (state_q == SEQ_READY);
   assign aif_en      = (state_q == SEQ_AIF_SETTLE) || (state_q == SEQ_READY);
   assign ready       = (state_q == SEQ_READY);
   assign err_flag    = err_q;

endmodule

// File: rtl/codec_pwrup_seq_chk.sv
module codec_pwrup_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       supply_ok,
   input logic       codec_rst_n,
   input logic       cmd_valid,
   input logic [7:0] cmd_addr,
   input logic [7:0] cmd_data,
   input logic       cmd_done,
   input logic       mclk_en,
   input logic       aif_en,
   input logic       ready,
   input logic       err_flag
);

   AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(codec_rst_n) |-> $past(supply_ok)) else $error("release without supply"); // R1

   AST_RELEASE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(codec_rst_n) |-> !cmd_valid) else $error("command at reset release"); // R2

   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_done && supply_ok) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)))
      else $error("command dropped or changed before done"); // R4

   AST_NO_CMD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !codec_rst_n |-> !cmd_valid) else $error("command while codec in reset"); // R4

   AST_MCLK_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mclk_en) |-> (!cmd_valid && codec_rst_n)) else $error("master clock start during write"); // R5

   AST_AIF_NEEDS_MCLK: assert property (@(posedge clk) disable iff (!rst_n)
      aif_en |-> mclk_en) else $error("audio interface without master clock"); // R7

   AST_READY_NEEDS_AIF: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (aif_en && !cmd_valid)) else $error("ready without audio interface"); // R8

   AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!codec_rst_n && !cmd_valid && !mclk_en && !aif_en && !ready))
      else $error("outputs active after supply drop"); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag) else $error("error flag cleared"); // R11

   AST_ERR_RISE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> (!codec_rst_n && !mclk_en && !cmd_valid)) else $error("fault not safe"); // R11

endmodule

bind codec_pwrup_seq codec_pwrup_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .supply_ok   (supply_ok),
   .codec_rst_n (codec_rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_addr    (cmd_addr),
   .cmd_data    (cmd_data),
   .cmd_done    (cmd_done),
   .mclk_en     (mclk_en),
   .aif_en      (aif_en),
   .ready       (ready),
   .err_flag    (err_flag)
);

// File: tb/codec_pwrup_seq_tb.sv
module codec_pwrup_seq_tb;

   localparam int RST_MIN = 20;
   localparam int STEP    = 5;
   localparam int SETTLE  = 10;
   localparam int RETRIES = 3;
   localparam int NCFG    = 3;
   localparam int LAT     = 3;
   localparam logic [NCFG*16-1:0] TABLE = {16'h0A_99, 16'h06_40, 16'h03_1C};

   typedef struct {
      logic [7:0] a;
      logic [7:0] d;
      logic       m;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       supply_ok;
   logic       codec_rst_n;
   logic       cmd_valid;
   logic [7:0] cmd_addr;
   logic [7:0] cmd_data;
   logic       cmd_done;
   logic       cmd_nack;
   logic       mclk_en;
   logic       aif_en;
   logic       frame_clk;
   logic       ready;
   logic       err_flag;

   int   n_chk = 0;
   int   n_fail = 0;
   exp_t q[$];
   bit   nack_plan[$];
   int   attempts = 0;
   int   ack_cnt = 0;
   int   drop_after = -1;
   bit   dropped = 0;

   always #2 clk = ~clk;

   codec_pwrup_seq #(
      .RST_MIN_CYCLES (RST_MIN),
      .STEP_CYCLES    (STEP),
      .SETTLE_FRAMES  (SETTLE),
      .MAX_RETRIES    (RETRIES),
      .CFG_COUNT      (NCFG),
      .CFG_TABLE      (TABLE)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok   (supply_ok),
      .codec_rst_n (codec_rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_addr    (cmd_addr),
      .cmd_data    (cmd_data),
      .cmd_done    (cmd_done),
      .cmd_nack    (cmd_nack),
      .mclk_en     (mclk_en),
      .aif_en      (aif_en),
      .frame_clk   (frame_clk),
      .ready       (ready),
      .err_flag    (err_flag)
   );

   task automatic check(bit ok, string tag, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic push_list();
      q.push_back('{a: 8'h02, d: 8'h01, m: 1'b0, tag: "R2 power-down set"});
      for (int i = 0; i < NCFG; i++)
         q.push_back('{a: TABLE[i*16+8 +: 8], d: TABLE[i*16 +: 8], m: 1'b0, tag: "R3 config entry"});
      q.push_back('{a: 8'h02, d: 8'h00, m: 1'b1, tag: "R6 power-down clear"});
   endtask

   // monitor and bus-master model: pops the scoreboard on every acknowledged write
   initial begin
      exp_t e;
      bit   nk;
      bit   held;
      bit   drop_now;
      cmd_done = 1'b0;
      cmd_nack = 1'b0;
      forever begin
         @(negedge clk);
         if (cmd_valid) begin
            logic [7:0] a0, d0;
            a0 = cmd_addr;
            d0 = cmd_data;
            held = 1'b1;
            for (int k = 0; k < LAT; k++) begin
               @(negedge clk);
               if (!cmd_valid || cmd_addr != a0 || cmd_data != d0) held = 1'b0;
            end
            check(held, "R4 request held stable", held, 1);
            attempts++;
            if (q.size() == 0) begin
               check(1'b0, "R4 unexpected command", {cmd_addr, cmd_data}, 0);
            end else begin
               e = q[0];
               check({cmd_addr, cmd_data} == {e.a, e.d}, e.tag, {cmd_addr, cmd_data}, {e.a, e.d});
               check(mclk_en == e.m, "R5 master clock state at write", mclk_en, e.m);
               check(!aif_en, "R7 audio interface off during write", aif_en, 0);
            end
            nk = (nack_plan.size() != 0) ? nack_plan.pop_front() : 1'b0;
            drop_now = !nk && (drop_after >= 0) && (ack_cnt == drop_after);
            cmd_done = 1'b1;
            cmd_nack = nk;
            if (drop_now) begin
               supply_ok  = 1'b0;
               dropped    = 1'b1;
               drop_after = -1;
            end
            @(negedge clk);
            cmd_done = 1'b0;
            cmd_nack = 1'b0;
            if (!nk && !drop_now) begin
               ack_cnt++;
               if (q.size() != 0) void'(q.pop_front());
            end
         end
      end
   end

   task automatic bringup();
      int n;
      push_list();
      supply_ok = 1'b0;
      repeat (3) @(negedge clk);
      supply_ok = 1'b1;
      repeat (RST_MIN / 2) @(negedge clk);
      supply_ok = 1'b0;
      @(negedge clk);
      check(!codec_rst_n, "R1 reset held during supply dip", codec_rst_n, 0);
      supply_ok = 1'b1;
      n = 0;
      forever begin
         @(negedge clk);
         if (codec_rst_n) break;
         n++;
      end
      check(n == RST_MIN, "R1 reset low cycles after supply good", n, RST_MIN);
      n = 0;
      while (!cmd_valid) begin
         @(negedge clk);
         n++;
      end
      check(n == STEP + 1, "R2 first command delay", n, STEP + 1);
      while (!aif_en) @(negedge clk);
      check(mclk_en, "R7 master clock on with audio interface", mclk_en, 1);
      @(negedge clk);
      check(q.size() == 0, "R3 all writes consumed in order", q.size(), 0);
      for (int i = 0; i < SETTLE - 1; i++) begin
         frame_clk = 1'b1;
         repeat (2) @(negedge clk);
         frame_clk = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check(!ready, "R8 not ready one frame short", ready, 0);
      frame_clk = 1'b1;
      repeat (3) @(negedge clk);
      check(!ready, "R8 ready not early", ready, 0);
      @(negedge clk);
      check(ready, "R8 ready on fourth edge", ready, 1);
      frame_clk = 1'b0;
   endtask

   initial begin
      bit seen;
      int n;
      rst_n     = 1'b0;
      supply_ok = 1'b0;
      frame_clk = 1'b0;
      repeat (5) @(negedge clk);
      check({codec_rst_n, cmd_valid, mclk_en, aif_en, ready, err_flag} == 6'b0,
            "R12 reset outputs", {codec_rst_n, cmd_valid, mclk_en, aif_en, ready, err_flag}, 0);
      rst_n = 1'b1;

      // plain bring-up, then supply loss while ready
      bringup();
      check(!err_flag, "R11 no error on clean run", err_flag, 0);
      supply_ok = 1'b0;
      @(negedge clk);
      check({codec_rst_n, mclk_en, aif_en, ready} == 4'b0, "R9 outputs after supply drop",
            {codec_rst_n, mclk_en, aif_en, ready}, 0);

      // two not-acknowledged attempts on the first write
      nack_plan.push_back(1'b1);
      nack_plan.push_back(1'b1);
      attempts = 0;
      bringup();
      check(attempts == NCFG + 4, "R10 retried attempts", attempts, NCFG + 4);
      check(!err_flag, "R10 retries within budget", err_flag, 0);

      // supply drop in the same cycle as an acknowledge
      supply_ok = 1'b0;
      repeat (3) @(negedge clk);
      ack_cnt    = 0;
      drop_after = 1;
      dropped    = 1'b0;
      push_list();
      supply_ok  = 1'b1;
      n = 0;
      while (!dropped && n < 5000) begin
         @(negedge clk);
         n++;
      end
      @(posedge clk);
      @(negedge clk);
      check({codec_rst_n, cmd_valid, mclk_en} == 3'b0, "R9 drop wins over acknowledge",
            {codec_rst_n, cmd_valid, mclk_en}, 0);
      q.delete();
      bringup();

      // retries exhausted
      supply_ok = 1'b0;
      repeat (3) @(negedge clk);
      q.delete();
      q.push_back('{a: 8'h02, d: 8'h01, m: 1'b0, tag: "R10 repeated power-down set"});
      for (int i = 0; i <= RETRIES; i++) nack_plan.push_back(1'b1);
      attempts  = 0;
      supply_ok = 1'b1;
      n = 0;
      while (!err_flag && n < 2000) begin
         @(negedge clk);
         n++;
      end
      check(err_flag, "R11 error flag on exhausted retries", err_flag, 1);
      @(negedge clk);
      check(attempts == RETRIES + 1, "R10 attempts before fault", attempts, RETRIES + 1);
      seen = 1'b0;
      repeat (30) begin
         @(negedge clk);
         if (cmd_valid || codec_rst_n || mclk_en) seen = 1'b1;
      end
      check(!seen, "R11 fault holds codec quiet", seen, 0);
      q.delete();
      bringup();
      check(err_flag, "R11 error flag sticky across restart", err_flag, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired: sequence hung");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule